// File: doc/BRIEF.md
# DMA Request Detector and Acknowledge Generator

This block sits in front of one DMA channel. It takes a raw request line, either from an on-chip peripheral or from an external pin, and turns it into a clean pending request for the channel. It also drives the acknowledge line back to the requester and gates the transfer-end indication.

External lines pass through a flop synchroniser before detection. Internal lines are sampled directly. The detection method is chosen per channel: rising edge, falling edge, either edge, low level, high level, or off.

- In the off setting, only a software strobe raises a request.
- A pending request is held on `req_o` until the channel accepts it with `accept_i`.
- The channel then runs one data unit and ends it with `unit_done_i`.
- During that unit the acknowledge is driven in one of three modes:
  - held for the whole unit;
  - asserted only during the bus access cycles of the selected side (source read or destination write);
  - never asserted.

Address generation and the bus transfers themselves are outside this block.

Top module: `dma_req_front`

## Requirements
- R1: While reset is applied and in the first cycle after it, `req_o`, `ack_o` and `tend_o` are all low.
- R2: With `line_is_ext_i`=1 the line passes through SYNC_STAGES flops (default 2) before detection. A rising edge mode request then appears three clock edges after the raw change. With `line_is_ext_i`=0 it appears at the first edge.
- R3: Detection code 3 is rising edge. A low-to-high change of the sampled line raises `req_o` at the next clock edge, and `req_o` stays high until `accept_i` is seen while `req_o` is high. No change is seen in the first sampled cycle after reset.
- R4: Detection code 4 is falling edge and code 5 is either edge. Each raises a request exactly like R3 for its own edge polarity.
- R5: In an edge mode, edges arriving while `req_o` is high are absorbed. Any number of edges during an accepted unit are stored as a single request, which is raised at the edge where `unit_done_i` ends the unit.
- R6: Code 2 is high level and code 1 is low level. `req_o` rises when the line is at the active level. It falls again with no acceptance if the line leaves that level before `accept_i`.
- R7: In a level mode the line is not looked at during an accepted unit. After `unit_done_i` the request stays low for one cycle, then rises again if the line is still active.
- R8: Code 0 (and unused codes 6 and 7) ignores the request line. A one-cycle `sw_req_i` strobe acts as the request edge instead.
- R9: Acknowledge mode 0 (level) drives `ack_o` high from the cycle after acceptance through the cycle in which `unit_done_i` is high. `ack_o` and `req_o` are never high together.
- R10: Acknowledge mode 1 (bus cycle) drives `ack_o` during an accepted unit only while `src_cycle_i` is high (`ack_dst_side_i`=0) or while `dst_cycle_i` is high (`ack_dst_side_i`=1).
- R11: Acknowledge modes 2 and 3 (masked) keep `ack_o` low.
- R12: `tend_o` follows `tend_i` only while a unit is accepted and not yet done. At any other time it is low.
- R13: `sw_req_i` has no effect in detection codes 1 to 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_line_i | input | 1 | Raw request line |
| line_is_ext_i | input | 1 | 1: line is an external pin, synchronised first |
| det_mode_i | input | 3 | Detection method code (R3 to R8) |
| sw_req_i | input | 1 | Software request strobe |
| ack_mode_i | input | 2 | Acknowledge output mode code (R9 to R11) |
| ack_dst_side_i | input | 1 | 1: acknowledge goes with the destination write cycles |
| accept_i | input | 1 | Channel accepts the pending request |
| src_cycle_i | input | 1 | Channel is in a source read bus cycle |
| dst_cycle_i | input | 1 | Channel is in a destination write bus cycle |
| unit_done_i | input | 1 | Current data unit completes |
| tend_i | input | 1 | Transfer-end indication from the channel |
| req_o | output | 1 | Pending request to the channel |
| ack_o | output | 1 | Acknowledge to the requester |
| tend_o | output | 1 | Gated transfer-end output |

## Verification
The assertions check the following on every cycle:
- acknowledge and request are never high together;
- a masked acknowledge never rises;
- an edge-mode request holds until accepted;
- the off mode never raises a request without the strobe;
- a level-mode unit always returns to the idle state on completion;
- the transfer end never overlaps a pending request.

Only the bench scenarios can show the rest:
- the exact synchroniser latency;
- the absorption of extra edges into one stored request;
- the withdrawal of a level request;
- the one-cycle gap before a level re-request;
- the side selection of bus-cycle acknowledge.

These are shown by comparing every clock against the reference model.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;

    typedef enum logic [2:0] {
        DET_OFF  = 3'd0,
        DET_LOW  = 3'd1,
        DET_HIGH = 3'd2,
        DET_RISE = 3'd3,
        DET_FALL = 3'd4,
        DET_BOTH = 3'd5
    } det_mode_e;

    typedef enum logic [1:0] {
        ACK_LEVEL = 2'd0,
        ACK_BUS   = 2'd1,
        ACK_MASK  = 2'd2
    } ack_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PEND   = 2'd1,
        ST_ACTIVE = 2'd2
    } req_state_e;

    typedef struct packed {
        req_state_e state;
        logic       prev;
        logic       primed;
        logic       stored;
    } det_regs_t;

endpackage

// File: rtl/dma_req_sync.sv
module dma_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/dma_req_detect.sv
module dma_req_detect
    import dma_req_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_i,
    input  logic [2:0] det_mode_i,
    input  logic       sw_req_i,
    input  logic       accept_i,
    input  logic       unit_done_i,
    output logic       req_o,
    output logic       active_o
);
    det_regs_t r_d, r_q;
    logic rise, fall, hit, level_kind, level_on;

    always_comb begin
        rise       = r_q.primed &  line_i & ~r_q.prev;
        fall       = r_q.primed & ~line_i &  r_q.prev;
        level_kind = 1'b0;
        level_on   = 1'b0;
        hit        = 1'b0;
        case (det_mode_i)
            DET_LOW:  begin level_kind = 1'b1; level_on = ~line_i; end
            DET_HIGH: begin level_kind = 1'b1; level_on =  line_i; end
            DET_RISE: hit = rise;
            DET_FALL: hit = fall;
            DET_BOTH: hit = rise | fall;
            default:  hit = sw_req_i;
        endcase

        r_d        = r_q;
        r_d.prev   = line_i;
        r_d.primed = 1'b1;
        case (r_q.state)
            ST_IDLE: begin
                if (level_kind ? level_on : hit) r_d.state = ST_PEND;
            end
            ST_PEND: begin
                if (accept_i) begin
                    r_d.state  = ST_ACTIVE;
                    r_d.stored = 1'b0;
                end else if (level_kind && !level_on) begin
                    r_d.state = ST_IDLE;
                end
            end
            ST_ACTIVE: begin
                if (!level_kind && hit) r_d.stored = 1'b1;
                if (unit_done_i) begin
                    r_d.state  = (!level_kind && (r_q.stored || hit)) ? ST_PEND : ST_IDLE;
                    r_d.stored = 1'b0;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: ST_IDLE, prev: 1'b0, primed: 1'b0, stored: 1'b0};
        else        r_q <= r_d;
    end

    assign req_o    = (r_q.state == ST_PEND);
    assign active_o = (r_q.state == ST_ACTIVE);

    // R3: an edge-mode request is held until the channel accepts it
    p_pend_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_PEND && !accept_i && !level_kind) |=> (r_q.state == ST_PEND));

    // R8: with detection off and no strobe an idle channel stays without a request
    p_off_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IDLE && (det_mode_i == 3'd0) && !sw_req_i) |=> (r_q.state != ST_PEND));

    // R7: a level-mode unit ends in idle, never straight back to pending
    p_level_rest_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_ACTIVE && unit_done_i && level_kind) |=> (r_q.state == ST_IDLE));
endmodule

// File: rtl/dma_req_ack.sv
module dma_req_ack
    import dma_req_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active_i,
    input  logic [1:0] ack_mode_i,
    input  logic       dst_side_i,
    input  logic       src_cycle_i,
    input  logic       dst_cycle_i,
    input  logic       tend_i,
    output logic       ack_o,
    output logic       tend_o
);
    logic side_cycle;

    always_comb begin
        side_cycle = dst_side_i ? dst_cycle_i : src_cycle_i;
        case (ack_mode_i)
            ACK_LEVEL: ack_o = active_i;
            ACK_BUS:   ack_o = active_i & side_cycle;
            default:   ack_o = 1'b0;
        endcase
        tend_o = active_i & tend_i;
    end

    // R11: masked acknowledge never rises
    p_ack_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_mode_i[1]) |-> !ack_o);
endmodule

// File: rtl/dma_req_front.sv
module dma_req_front #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_line_i,
    input  logic       line_is_ext_i,
    input  logic [2:0] det_mode_i,
    input  logic       sw_req_i,
    input  logic [1:0] ack_mode_i,
    input  logic       ack_dst_side_i,
    input  logic       accept_i,
    input  logic       src_cycle_i,
    input  logic       dst_cycle_i,
    input  logic       unit_done_i,
    input  logic       tend_i,
    output logic       req_o,
    output logic       ack_o,
    output logic       tend_o
);
    logic synced, line, active;

    dma_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(req_line_i), .q_o(synced)
    );

    assign line = line_is_ext_i ? synced : req_line_i;

    dma_req_detect u_detect (
        .clk(clk), .rst_n(rst_n), .line_i(line), .det_mode_i(det_mode_i),
        .sw_req_i(sw_req_i), .accept_i(accept_i), .unit_done_i(unit_done_i),
        .req_o(req_o), .active_o(active)
    );

    dma_req_ack u_ack (
        .clk(clk), .rst_n(rst_n), .active_i(active), .ack_mode_i(ack_mode_i),
        .dst_side_i(ack_dst_side_i), .src_cycle_i(src_cycle_i),
        .dst_cycle_i(dst_cycle_i), .tend_i(tend_i), .ack_o(ack_o), .tend_o(tend_o)
    );

    // R9: acknowledge and pending request never overlap
    p_ack_excl_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> !req_o);

    // R12: transfer end never shows while a request is only pending
    p_tend_in_unit_r12: assert property (@(posedge clk) disable iff (!rst_n)
        tend_o |-> !req_o);
endmodule

// File: tb/dma_req_front_bench.sv
module dma_req_front_bench;
    localparam int S = 2;

    logic clk = 0, rst_n = 0;
    logic raw = 0, ext = 0, sw = 0, dst = 0, acc = 0, rdc = 0, wrc = 0, done = 0, te = 0;
    logic [2:0] dm = 3;
    logic [1:0] am = 0;
    logic req_o, ack_o, tend_o;
    int errors = 0, checks = 0, cycles = 0;
    string tag = "R1";

    always #5 clk = ~clk;

    dma_req_front #(.SYNC_STAGES(S)) u_dma_req_front (
        .clk(clk), .rst_n(rst_n), .req_line_i(raw), .line_is_ext_i(ext),
        .det_mode_i(dm), .sw_req_i(sw), .ack_mode_i(am), .ack_dst_side_i(dst),
        .accept_i(acc), .src_cycle_i(rdc), .dst_cycle_i(wrc), .unit_done_i(done),
        .tend_i(te), .req_o(req_o), .ack_o(ack_o), .tend_o(tend_o)
    );

    // behavioural reference model: 0 idle, 1 waiting, 2 unit running
    int m_st = 0;
    bit m_sync[S];
    bit m_prev = 0, m_prime = 0, m_store = 0;

    always @(posedge clk) begin
        bit ln, r, f, h, lk, lo;
        if (!rst_n) begin
            m_st = 0; m_prev = 0; m_prime = 0; m_store = 0;
            for (int i = 0; i < S; i++) m_sync[i] = 0;
        end else begin
            ln = ext ? m_sync[S-1] : raw;
            r = m_prime && ln && !m_prev;
            f = m_prime && !ln && m_prev;
            lk = (dm == 1 || dm == 2);
            lo = (dm == 1) ? !ln : ln;
            h = (dm == 3) ? r : (dm == 4) ? f : (dm == 5) ? (r || f) : lk ? 0 : sw;
            if (m_st == 0) begin
                if (lk ? lo : h) m_st = 1;
            end else if (m_st == 1) begin
                if (acc) begin m_st = 2; m_store = 0; end
                else if (lk && !lo) m_st = 0;
            end else begin
                if (!lk && h) m_store = 1;
                if (done) begin m_st = (!lk && (m_store || h)) ? 1 : 0; m_store = 0; end
            end
            for (int i = S - 1; i > 0; i--) m_sync[i] = m_sync[i-1];
            m_sync[0] = raw;
            m_prev = ln; m_prime = 1;
        end
    end

    task automatic expect_bit(string t, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b", t, what, act, exp);
        end
    endtask

    task automatic compare();
        logic e_ack;
        e_ack = (m_st == 2) && (am == 0 || (am == 1 && (dst ? wrc : rdc)));
        expect_bit(tag, "req_o", req_o, m_st == 1);
        expect_bit(tag, "ack_o", ack_o, e_ack);
        expect_bit(tag, "tend_o", tend_o, (m_st == 2) && te);
    endtask

    task automatic cyc(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1; compare();
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected<100000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1 reset
        tag = "R1";
        cyc(2);
        expect_bit("R1", "req_o in reset", req_o, 0);
        rst_n = 1; cyc(1);
        expect_bit("R1", "ack_o after reset", ack_o, 0);
        cyc(1);

        // R3 rising edge, R9 level acknowledge, R12 transfer end
        tag = "R3"; dm = 3; am = 0;
        raw = 1; cyc(1);
        expect_bit("R3", "req after rise", req_o, 1);
        cyc(3);
        expect_bit("R3", "req held", req_o, 1);
        tag = "R9"; acc = 1; cyc(1); acc = 0;
        expect_bit("R9", "ack after accept", ack_o, 1);
        tag = "R12"; te = 1; cyc(1);
        expect_bit("R12", "tend in unit", tend_o, 1);
        done = 1; cyc(1); done = 0; te = 0;
        cyc(1);
        expect_bit("R9", "ack after done", ack_o, 0);
        te = 1; cyc(2);
        expect_bit("R12", "tend idle", tend_o, 0);
        te = 0; raw = 0; cyc(2);

        // R5 edges absorbed while pending, stored once while active
        tag = "R5";
        raw = 1; cyc(1); raw = 0; cyc(1); raw = 1; cyc(1);
        acc = 1; cyc(1); acc = 0;
        raw = 0; cyc(1); raw = 1; cyc(1); raw = 0; cyc(1); raw = 1; cyc(1);
        done = 1; cyc(1); done = 0;
        expect_bit("R5", "stored request", req_o, 1);
        acc = 1; cyc(1); acc = 0; done = 1; cyc(1); done = 0;
        expect_bit("R5", "only one stored", req_o, 0);
        raw = 0; cyc(2);

        // R4 falling and both edges
        tag = "R4"; dm = 4;
        raw = 1; cyc(1);
        expect_bit("R4", "no req on rise in fall mode", req_o, 0);
        raw = 0; cyc(1);
        expect_bit("R4", "req on fall", req_o, 1);
        acc = 1; cyc(1); acc = 0; done = 1; cyc(1); done = 0;
        dm = 5; raw = 1; cyc(1);
        expect_bit("R4", "both: rise", req_o, 1);
        acc = 1; cyc(1); acc = 0; done = 1; cyc(1); done = 0;
        raw = 0; cyc(1);
        expect_bit("R4", "both: fall", req_o, 1);
        acc = 1; cyc(1); acc = 0; done = 1; cyc(2); done = 0;

        // R2 synchroniser latency
        tag = "R2"; dm = 3; ext = 1; cyc(3);
        raw = 1; cyc(2);
        expect_bit("R2", "not yet through sync", req_o, 0);
        cyc(1);
        expect_bit("R2", "through sync", req_o, 1);
        acc = 1; cyc(1); acc = 0; done = 1; cyc(1); done = 0;
        raw = 0; cyc(4); ext = 0; cyc(1);

        // R6 level modes and withdrawal
        tag = "R6"; dm = 2;
        raw = 1; cyc(1);
        expect_bit("R6", "high level req", req_o, 1);
        raw = 0; cyc(1);
        expect_bit("R6", "withdrawn", req_o, 0);
        dm = 1; cyc(1);
        expect_bit("R6", "low level req", req_o, 1);
        // R7 no re-evaluation during unit, gap after done
        tag = "R7"; acc = 1; cyc(1); acc = 0; cyc(2);
        done = 1; cyc(1); done = 0;
        expect_bit("R7", "gap after done", req_o, 0);
        cyc(1);
        expect_bit("R7", "re-request", req_o, 1);
        acc = 1; cyc(1); acc = 0; raw = 1; done = 1; cyc(1); done = 0; cyc(2);

        // R8 off mode; R13 strobe ignored in hardware mode
        tag = "R8"; dm = 0;
        raw = 0; cyc(1); raw = 1; cyc(1);
        expect_bit("R8", "line ignored", req_o, 0);
        sw = 1; cyc(1); sw = 0;
        expect_bit("R8", "strobe request", req_o, 1);
        acc = 1; cyc(1); acc = 0; done = 1; cyc(1); done = 0;
        tag = "R13"; dm = 3; cyc(1); sw = 1; cyc(1); sw = 0;
        expect_bit("R13", "strobe ignored", req_o, 0);
        cyc(1);

        // R10 bus-cycle acknowledge, both sides
        tag = "R10"; am = 1; dst = 0;
        raw = 0; cyc(1); raw = 1; cyc(1); acc = 1; cyc(1); acc = 0;
        expect_bit("R10", "no bus cycle", ack_o, 0);
        rdc = 1; cyc(1);
        expect_bit("R10", "src cycle", ack_o, 1);
        rdc = 0; wrc = 1; cyc(1);
        expect_bit("R10", "dst cycle, src side", ack_o, 0);
        dst = 1; cyc(1);
        expect_bit("R10", "dst side", ack_o, 1);
        wrc = 0; done = 1; cyc(1); done = 0;

        // R11 masked acknowledge
        tag = "R11"; am = 2; dst = 0;
        raw = 0; cyc(1); raw = 1; cyc(1); acc = 1; cyc(1); acc = 0;
        rdc = 1; wrc = 1; cyc(2);
        expect_bit("R11", "masked", ack_o, 0);
        am = 3; cyc(1);
        expect_bit("R11", "masked code 3", ack_o, 0);
        rdc = 0; wrc = 0; done = 1; cyc(1); done = 0; cyc(2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule